// File: doc/BRIEF.md
# Byte-Programmed 16-bit Reload Timer

This block is a 16-bit down counter with a 16-bit reload value, driven from an 8-bit register bus. Software reaches it through three addresses: the low byte of the count, the high byte of the count, and a mode byte. The counter steps down once per count event. When it already holds zero, the next count event is an underflow. An underflow copies the reload value back into the counter and latches an interrupt request that stays set until it is cleared. The result is a divider with ratio 1/(n+1) for a programmed value n.

A 16-bit value cannot be loaded in one access. Software writes the low byte first, and that byte is held in a hidden staging register. The high-byte write then commits both halves to the reload value together. A mode bit chooses what happens to the counter on that commit: it is either loaded at once, or it keeps running and picks up the new value at its next underflow. Reads work the other way round. A high-byte read freezes the low byte, so the low-byte read that follows matches it.

The mode field chooses the count source and the output behaviour. In timer mode and pulse-output mode the block counts an external count-enable pulse. In event-counter mode it counts rising edges of a pin, after synchronising them. In pulse-output mode an output pin toggles on each underflow. The fourth encoding stops counting.

Top module: `reload_timer16`

## Requirements
- R1: In timer mode (mode bits 5:4 = 00), each cycle with `cnt_pulse` high decrements a nonzero counter by one.
- R2: A count event while the counter holds 0000h is an underflow. It loads the reload value into the counter, so a reload value n gives one underflow every n+1 count events.
- R3: Each underflow sets `irq_flag` on the following cycle. `irq_flag` stays set until a cycle with `irq_clr` high. When an underflow and `irq_clr` fall in the same cycle, the flag stays set.
- R4: A write to address 0 (low byte) only loads the staging register. The counter and the reload value do not change.
- R5: A write to address 1 (high byte) sets the reload value to {written byte, staged low byte}. If mode bit 0 is 0, the counter takes that value on the same clock edge.
- R6: If mode bit 0 is 1, a high-byte write leaves the counter running. The new reload value enters the counter at the next underflow.
- R7: After synchronous reset, the counter and reload value are FFFFh, the mode byte is 00h, `irq_flag` is 0 and `pulse_out` is 0.
- R8: When a count event and a high-byte write with mode bit 0 = 0 fall in the same cycle, the counter takes the written value and does not decrement, and no underflow occurs.
- R9: In pulse-output mode (bits 5:4 = 01), `pulse_out` toggles on every underflow. In every other mode `pulse_out` holds its value.
- R10: In event-counter mode (bits 5:4 = 10), `cnt_pulse` is ignored. Each rising edge of `ev_pin`, passed through two synchroniser flip-flops, counts exactly once, however long the pin stays high.
- R11: With mode bits 5:4 = 11, the counter holds its value whatever arrives on `cnt_pulse` or `ev_pin`.
- R12: The read data is combinational on `bus_addr` while `bus_rd` is high:
  - Address 1 returns the live high byte and, on that clock edge, copies the live low byte into a read buffer.
  - Address 0 returns the read buffer.
  - Address 2 returns the mode byte.
  - Address 3 reads 00h, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 mode |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| cnt_pulse | input | 1 | Count-enable pulse (timer and pulse-output modes) |
| ev_pin | input | 1 | Asynchronous event input (event-counter mode) |
| irq_clr | input | 1 | Clears the interrupt request flag |
| irq_flag | output | 1 | Interrupt request, set on underflow |
| pulse_out | output | 1 | Toggles on underflow in pulse-output mode |

## Verification
The bench targets several corner cases, each of which a faulty design would show in a visible way:
- **Low byte alone.** It writes only the low byte and checks that the counter has not moved; a design without staging would expose a half-written value.
- **Reload period.** It counts underflows at reload value 2, where an off-by-one would fire after two events instead of three.
- **Deferred load.** It checks that the counter keeps its old value until the next underflow, rather than jumping at once.
- **Collision.** It lands a count pulse on the same edge as an immediate high-byte write; a wrong priority would leave the counter one below the written value.
- **Long event pulse.** It holds `ev_pin` high for many cycles; a design counting level instead of edge would count more than once.
- **Read snapshot.** It lets the counter cross a byte boundary between the high-byte read and the low-byte read; a design without the snapshot would return a torn value.

// File: rtl/rt16_pkg.sv
// Package: shared types and constants for the 16-bit reload timer.
// Assumes a byte-wide register bus with a 2-bit address.
package rt16_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    // Operating mode held in mode bits 5:4
    typedef enum logic [1:0] {
        MODE_TIMER  = 2'b00,
        MODE_PULSE  = 2'b01,
        MODE_EVENT  = 2'b10,
        MODE_HOLD   = 2'b11
    } rt_mode_e;

    localparam logic [ADDR_W-1:0] ADR_LO   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_MODE = 2'd2;

    localparam int MODE_DEFER_BIT = 0;
    localparam int MODE_SEL_LSB   = 4;
endpackage

// File: rtl/rt16_evsync.sv
// Module: rt16_evsync
// Brings an asynchronous pin into the clock domain through a chain of
// flip-flops and emits a one-cycle pulse for each rising edge.
// Assumes the pin stays at each level for longer than one clock period.
module rt16_evsync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // First stage samples the raw pin
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin_async;
    end

    // Remaining synchroniser stages
    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    endgenerate

    // Delayed copy of the synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    // Edge detect on the synchronised level
    always_comb rise_pulse = sync_q[SYNC_STAGES-1] & ~last_q;

    // R10
    ev_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/rt16_regif.sv
// Module: rt16_regif
// Register bus front end: low-byte staging, high-byte commit, mode byte,
// and the read buffer that keeps the two halves of a read coherent.
// Assumes at most one access (read or write) per cycle.
module rt16_regif
    import rt16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [CNT_W-1:0]    cnt_live,
    output logic [BYTE_W-1:0]   mode_q,
    output logic                commit,
    output logic [CNT_W-1:0]    commit_val
);
    localparam int LO_W = CNT_W - BYTE_W;

    logic [LO_W-1:0] stage_q;
    logic [LO_W-1:0] rdbuf_q;
    logic            wr_lo, wr_hi, wr_mode, rd_hi;

    // Access decode
    always_comb begin
        wr_lo   = bus_wr && (bus_addr == ADR_LO);
        wr_hi   = bus_wr && (bus_addr == ADR_HI);
        wr_mode = bus_wr && (bus_addr == ADR_MODE);
        rd_hi   = bus_rd && (bus_addr == ADR_HI);
    end

    // Hidden low-byte staging register
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= '1;
        else if (wr_lo) stage_q <= LO_W'(bus_wdata);
    end

    // Mode byte
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= bus_wdata;
    end

    // Read buffer: low half frozen on a high-byte read
    always_ff @(posedge clk) begin
        if (!rst_n)     rdbuf_q <= '1;
        else if (rd_hi) rdbuf_q <= cnt_live[LO_W-1:0];
    end

    // Atomic commit of both halves on the high-byte write
    always_comb begin
        commit     = wr_hi;
        commit_val = {bus_wdata, stage_q};
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                ADR_LO:   bus_rdata = rdbuf_q[BYTE_W-1:0];
                ADR_HI:   bus_rdata = cnt_live[CNT_W-1:LO_W];
                ADR_MODE: bus_rdata = mode_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R4
    stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |-> !commit);
    // R12
    rdbuf_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> rdbuf_q == $past(cnt_live[LO_W-1:0]));
endmodule

// File: rtl/rt16_core.sv
// Module: rt16_core
// Counter, reload value, underflow detection, interrupt flag and pulse
// output toggle. Count qualification by mode is done by the caller.
// Assumes tick is already gated for the selected mode.
module rt16_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_val,
    input  logic             defer_load,
    input  logic             toggle_en,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_flag,
    output logic             pulse_out
);
    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] latch_next;
    logic             load_now;
    logic             underflow;

    // Next reload value including a commit in this cycle
    always_comb begin
        latch_next = commit ? commit_val : latch_q;
        load_now   = commit && !defer_load;
        underflow  = tick && (cnt_q == '0) && !load_now;
    end

    // Reload value register
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '1;
        else        latch_q <= latch_next;
    end

    // Down counter with immediate load taking priority over counting
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '1;
        else if (load_now)  cnt_q <= commit_val;
        else if (underflow) cnt_q <= latch_next;
        else if (tick)      cnt_q <= cnt_q - 1'b1;
    end

    // Interrupt request flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_flag <= 1'b0;
        else if (underflow) irq_flag <= 1'b1;
        else if (irq_clr)   irq_flag <= 1'b0;
    end

    // Pulse output toggle
    always_ff @(posedge clk) begin
        if (!rst_n)                      pulse_out <= 1'b0;
        else if (underflow && toggle_en) pulse_out <= ~pulse_out;
    end

    // R3
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> irq_flag);
    // R3
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);
    // R5
    load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> cnt_q == $past(commit_val));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_now) |=> $stable(cnt_q));
    // R9
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(underflow && toggle_en) |=> $stable(pulse_out));
endmodule

// File: rtl/reload_timer16.sv
// Module: reload_timer16
// Top level of the 16-bit reload timer: register front end, event-pin
// synchroniser, count-source selection by mode, and the counter core.
// Assumes a single clock domain apart from ev_pin.
module reload_timer16
    import rt16_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cnt_pulse,
    input  logic              ev_pin,
    input  logic              irq_clr,
    output logic              irq_flag,
    output logic              pulse_out
);
    logic [CNT_W-1:0]  cnt_live;
    logic [BYTE_W-1:0] mode_q;
    logic              commit;
    logic [CNT_W-1:0]  commit_val;
    logic              ev_rise;
    logic              tick;
    rt_mode_e          mode_sel;

    rt16_regif #(.CNT_W(CNT_W)) regif_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt_live   (cnt_live),
        .mode_q     (mode_q),
        .commit     (commit),
        .commit_val (commit_val)
    );

    rt16_evsync #(.SYNC_STAGES(SYNC_STAGES)) evsync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (ev_pin),
        .rise_pulse (ev_rise)
    );

    // Count source selection from mode bits 5:4
    always_comb begin
        mode_sel = rt_mode_e'(mode_q[MODE_SEL_LSB +: 2]);
        unique case (mode_sel)
            MODE_TIMER: tick = cnt_pulse;
            MODE_PULSE: tick = cnt_pulse;
            MODE_EVENT: tick = ev_rise;
            default:    tick = 1'b0;
        endcase
    end

    rt16_core #(.CNT_W(CNT_W)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .commit     (commit),
        .commit_val (commit_val),
        .defer_load (mode_q[MODE_DEFER_BIT]),
        .toggle_en  (mode_sel == MODE_PULSE),
        .irq_clr    (irq_clr),
        .cnt_q      (cnt_live),
        .irq_flag   (irq_flag),
        .pulse_out  (pulse_out)
    );

    // R11
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_HOLD && !commit) |=> $stable(cnt_live));
    // R10
    event_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_EVENT && !ev_rise && !commit) |=> $stable(cnt_live));
endmodule

// File: tb/reload_timer16_tb_top.sv
// Directed bench for reload_timer16: one task per scenario.
module reload_timer16_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bus_addr;
    logic       bus_wr, bus_rd, cnt_pulse, ev_pin, irq_clr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq_flag, pulse_out;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_timer16 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_pulse(cnt_pulse), .ev_pin(ev_pin), .irq_clr(irq_clr),
        .irq_flag(irq_flag), .pulse_out(pulse_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks begin and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] h, l;
        rd(2'd1, h);
        rd(2'd0, l);
        v = {h, l};
    endtask

    task automatic load16(input logic [15:0] v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_pulse = 1'b1;
            @(posedge clk); @(negedge clk);
            cnt_pulse = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v; logic [7:0] m;
        rd16(v);       check("R7 counter", v, 16'hFFFF);
        rd(2'd2, m);   check("R7 mode", m, 8'h00);
        check("R7 irq", irq_flag, 1'b0);
        check("R7 pulse_out", pulse_out, 1'b0);
    endtask

    task automatic t_staging;
        logic [15:0] v;
        wr(2'd0, 8'h34);
        rd16(v);  check("R4 low write staged", v, 16'hFFFF);
        wr(2'd1, 8'h00);
        rd16(v);  check("R5 immediate commit", v, 16'h0034);
        pulses(5);
        rd16(v);  check("R1 decrement", v, 16'h002F);
    endtask

    task automatic t_underflow;
        logic [15:0] v;
        load16(16'h0002);
        pulses(2);
        check("R2 no underflow after n events", irq_flag, 1'b0);
        pulses(1);
        check("R3 irq on underflow", irq_flag, 1'b1);
        rd16(v);  check("R2 reload", v, 16'h0002);
        pulses(3);
        rd16(v);  check("R2 second period", v, 16'h0002);
        check("R3 irq held", irq_flag, 1'b1);
        check("R9 timer mode no toggle", pulse_out, 1'b0);
        irq_clr = 1'b1; @(posedge clk); @(negedge clk); irq_clr = 1'b0;
        check("R3 irq cleared", irq_flag, 1'b0);
    endtask

    task automatic t_set_wins;
        load16(16'h0000);
        irq_clr = 1'b1; cnt_pulse = 1'b1;
        @(posedge clk); @(negedge clk);
        irq_clr = 1'b0; cnt_pulse = 1'b0;
        check("R3 set wins over clear", irq_flag, 1'b1);
        irq_clr = 1'b1; @(posedge clk); @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic t_deferred;
        logic [15:0] v;
        load16(16'h0002);
        wr(2'd2, 8'h01);
        load16(16'h0010);
        rd16(v);  check("R6 counter unchanged", v, 16'h0002);
        pulses(3);
        rd16(v);  check("R6 new value at underflow", v, 16'h0010);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_collision;
        logic [15:0] v;
        load16(16'h0400);
        wr(2'd0, 8'h55);
        bus_addr = 2'd1; bus_wdata = 8'h12; bus_wr = 1'b1; cnt_pulse = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; cnt_pulse = 1'b0;
        rd16(v);  check("R8 write wins", v, 16'h1255);
    endtask

    task automatic t_pulse_mode;
        wr(2'd2, 8'h10);
        load16(16'h0001);
        pulses(2);
        check("R9 toggle high", pulse_out, 1'b1);
        pulses(1);
        check("R9 no toggle mid period", pulse_out, 1'b1);
        pulses(1);
        check("R9 toggle low", pulse_out, 1'b0);
    endtask

    task automatic t_event_mode;
        logic [15:0] v;
        wr(2'd2, 8'h20);
        load16(16'h0005);
        pulses(3);
        rd16(v);  check("R10 cnt_pulse ignored", v, 16'h0005);
        ev_pin = 1'b1; idle(8);
        rd16(v);  check("R10 one count per edge", v, 16'h0004);
        ev_pin = 1'b0; idle(4);
        ev_pin = 1'b1; idle(4);
        rd16(v);  check("R10 second edge", v, 16'h0003);
        ev_pin = 1'b0; idle(4);
    endtask

    task automatic t_hold_mode;
        logic [15:0] v;
        wr(2'd2, 8'h30);
        load16(16'h0007);
        pulses(3);
        ev_pin = 1'b1; idle(5); ev_pin = 1'b0; idle(4);
        rd16(v);  check("R11 held", v, 16'h0007);
    endtask

    task automatic t_read_snapshot;
        logic [7:0] h, l, m;
        wr(2'd2, 8'h00);
        load16(16'h0100);
        rd(2'd1, h);  check("R12 high byte", h, 8'h01);
        pulses(1);
        rd(2'd0, l);  check("R12 snapshot low", l, 8'h00);
        rd(2'd1, h);  check("R12 live high after step", h, 8'h00);
        rd(2'd0, l);  check("R12 live low after step", l, 8'hFF);
        wr(2'd3, 8'hAA);
        rd(2'd3, m);  check("R12 unused address", m, 8'h00);
        rd(2'd2, m);  check("R12 mode readback", m, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        cnt_pulse = 0; ev_pin = 0; irq_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_staging;
        t_underflow;
        t_set_wins;
        t_deferred;
        t_collision;
        t_pulse_mode;
        t_event_mode;
        t_hold_mode;
        t_read_snapshot;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule